// File: doc/BRIEF.md
# Flash Command Launch and Status Front End

This block sits between a register bus and the back-end sequencer of a flash controller. A single 32-bit register write carries the whole command descriptor: the flash opcode, the target device and buffer, the transfer length, whether error correction is applied, whether the opcode is a multi-cycle one, whether to start now, and whether an interrupt is wanted at the end. When the start bit is set and no command is running, the block latches the descriptor, gives the sequencer a one-cycle start pulse and reports busy until the sequencer signals done.

On completion the block loads the sequencer's correction results, but only for a command that had error correction enabled. It raises a completion interrupt only if the launching write asked for one. Software reads busy and the two correction flags back through the same register. Writing the all-zero word clears a pending interrupt and does nothing else. Pin-level flash timing and the correction arithmetic belong to the sequencer and are seen here only as a start/done handshake.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, busy, both correction flags, the interrupt and the start pulse are all 0, and the read word is 0.
- R2: A write with bit 31 set while idle produces exactly one seq_start pulse in the cycle after the write. The pulse carries opcode = bits 23:16, buffer select = bit 14, device select = bits 13:12, correction enable = bit 11, multi-cycle = bit 10 and length = bits 9:0. Read bit 31 (busy) is 1 from that same cycle.
- R3: While busy, a write with bit 31 set is ignored: no start pulse is produced, and the descriptor outputs keep the values of the command in flight.
- R4: Busy returns to 0 in the cycle after seq_done is seen while busy. A seq_done that arrives while idle changes nothing.
- R5: Read bit 11 reports a corrected single-bit error and read bit 10 an uncorrectable double-bit error. Both are cleared in the cycle the start pulse appears. They are loaded from the sequencer flags on done only when the command had correction enabled, and otherwise stay 0.
- R6: irq rises in the cycle after done only if bit 30 was set in the launching write, and then stays 1 until it is cleared.
- R7: A write of the all-zero word clears irq in the next cycle and starts nothing.
- R8: A nonzero write with bit 31 clear starts nothing and leaves irq unchanged.
- R9: When done and an all-zero write arrive in the same cycle, setting irq takes priority over clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write word |
| reg_rd_data | output | 32 | Status read word: busy, corrected, uncorrectable |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_opcode | output | 8 | Latched flash opcode |
| seq_buf_sel | output | 1 | Latched buffer select |
| seq_dev_sel | output | 2 | Latched device select |
| seq_ecc_en | output | 1 | Latched correction enable |
| seq_multi | output | 1 | Latched multi-cycle flag |
| seq_len | output | 10 | Latched transfer length in bytes |
| seq_done | input | 1 | Command complete from the sequencer |
| seq_err_single | input | 1 | Single-bit error corrected, valid with done |
| seq_err_double | input | 1 | Uncorrectable error, valid with done, |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default field widths: an 8-bit opcode, a 2-bit device select and a 10-bit length. These widths match the fixed bit positions of the register word, so the extreme values 0xFF, device 3 and length 1023 can be driven as boundary patterns. Sequences cover a launch attempted while busy, a done arriving while idle, commands with and without correction and with and without an interrupt request, and a done that coincides with a clearing write.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  localparam int WORD_W = 32;
  localparam int OPC_W  = 8;
  localparam int DEV_W  = 2;
  localparam int LEN_W  = 10;

  // Bit positions in the register word (decoded by software, so fixed).
  localparam int B_GO     = 31;
  localparam int B_IRQREQ = 30;
  localparam int B_OPC_LO = 16;
  localparam int B_BUF    = 14;
  localparam int B_DEV_LO = 12;
  localparam int B_ECC    = 11;
  localparam int B_MULTI  = 10;
  localparam int B_LEN_LO = 0;

  // Read-side positions.
  localparam int R_BUSY = 31;
  localparam int R_SGL  = 11;
  localparam int R_DBL  = 10;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic             buf_sel;
    logic [DEV_W-1:0] dev_sel;
    logic             ecc_en;
    logic             multi;
    logic [LEN_W-1:0] len;
  } cmd_desc_t;

  function automatic cmd_desc_t word_to_desc(input logic [WORD_W-1:0] w);
    cmd_desc_t d;
    d.opcode  = w[B_OPC_LO +: OPC_W];
    d.buf_sel = w[B_BUF];
    d.dev_sel = w[B_DEV_LO +: DEV_W];
    d.ecc_en  = w[B_ECC];
    d.multi   = w[B_MULTI];
    d.len     = w[B_LEN_LO +: LEN_W];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic busy,
                                                    input logic sgl,
                                                    input logic dbl);
    logic [WORD_W-1:0] w;
    w         = '0;
    w[R_BUSY] = busy;
    w[R_SGL]  = sgl;
    w[R_DBL]  = dbl;
    return w;
  endfunction

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_cmd_pkg::*;
(
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output logic              launch_evt,
  output logic              blocked_evt,
  output logic              zero_wr_evt,
  output logic              want_irq,
  output cmd_desc_t         desc
);

  logic go_bit;

  always_comb begin
    go_bit      = wr_en && wr_data[B_GO];
    launch_evt  = go_bit && !busy;
    blocked_evt = go_bit && busy;
    zero_wr_evt = wr_en && (wr_data == '0);
    want_irq    = wr_data[B_IRQREQ];
    desc        = word_to_desc(wr_data);
  end

endmodule

// File: rtl/nand_cmd_track.sv
module nand_cmd_track
  import nand_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch_evt,
  input  logic      blocked_evt,
  input  cmd_desc_t desc_in,
  input  logic      want_irq,
  input  logic      seq_done,
  output logic      busy,
  output logic      start,
  output cmd_desc_t desc_q,
  output logic      irq_req_q,
  output logic      done_evt
);

  assign done_evt = busy && seq_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      start     <= 1'b0;
      desc_q    <= '0;
      irq_req_q <= 1'b0;
    end else begin
      start <= launch_evt;
      if (launch_evt) begin
        busy      <= 1'b1;
        desc_q    <= desc_in;
        irq_req_q <= want_irq;
      end else if (done_evt) begin
        busy <= 1'b0;
      end
    end
  end

  // R2: start lasts one cycle
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R3: launch attempt while busy gives no start and keeps descriptor
  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> (!start && $stable(desc_q)));
  // R4: busy drops after done
  a_r4_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
  // R2: busy is high whenever start is
  a_r2_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

endmodule

// File: rtl/nand_cmd_status.sv
module nand_cmd_status
  import nand_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_evt,
  input  logic done_evt,
  input  logic ecc_q,
  input  logic irq_req_q,
  input  logic zero_wr_evt,
  input  logic in_sgl,
  input  logic in_dbl,
  output logic err_sgl,
  output logic err_dbl,
  output logic irq
);

  logic load_err;
  logic irq_set;

  assign load_err = done_evt && ecc_q;
  assign irq_set  = done_evt && irq_req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sgl <= 1'b0;
      err_dbl <= 1'b0;
    end else if (launch_evt) begin
      err_sgl <= 1'b0;
      err_dbl <= 1'b0;
    end else if (load_err) begin
      err_sgl <= in_sgl;
      err_dbl <= in_dbl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           irq <= 1'b0;
    else if (irq_set)     irq <= 1'b1;
    else if (zero_wr_evt) irq <= 1'b0;
  end

  // R7: zero write without a coinciding set clears irq
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_wr_evt && !irq_set) |=> !irq);
  // R6: irq holds until a zero write
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !zero_wr_evt) |=> irq);
  // R9: done wins over a simultaneous clear
  a_r9_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);
  // R5: flags stay put without done or launch
  a_r5_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_evt && !done_evt) |=> ($stable(err_sgl) && $stable(err_dbl)));
  // R6: irq only rises on a requested completion
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_set));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  output logic              seq_start,
  output logic [OPC_W-1:0]  seq_opcode,
  output logic              seq_buf_sel,
  output logic [DEV_W-1:0]  seq_dev_sel,
  output logic              seq_ecc_en,
  output logic              seq_multi,
  output logic [LEN_W-1:0]  seq_len,
  input  logic              seq_done,
  input  logic              seq_err_single,
  input  logic              seq_err_double,
  output logic              irq
);

  logic      launch_evt, blocked_evt, zero_wr_evt, want_irq;
  logic      busy, irq_req_q, done_evt, err_sgl, err_dbl;
  cmd_desc_t desc_w, desc_q;

  nand_cmd_decode u_dec (
    .wr_en       (reg_wr_en),
    .wr_data     (reg_wr_data),
    .busy        (busy),
    .launch_evt  (launch_evt),
    .blocked_evt (blocked_evt),
    .zero_wr_evt (zero_wr_evt),
    .want_irq    (want_irq),
    .desc        (desc_w)
  );

  nand_cmd_track u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_evt  (launch_evt),
    .blocked_evt (blocked_evt),
    .desc_in     (desc_w),
    .want_irq    (want_irq),
    .seq_done    (seq_done),
    .busy        (busy),
    .start       (seq_start),
    .desc_q      (desc_q),
    .irq_req_q   (irq_req_q),
    .done_evt    (done_evt)
  );

  nand_cmd_status u_sts (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_evt  (launch_evt),
    .done_evt    (done_evt),
    .ecc_q       (desc_q.ecc_en),
    .irq_req_q   (irq_req_q),
    .zero_wr_evt (zero_wr_evt),
    .in_sgl      (seq_err_single),
    .in_dbl      (seq_err_double),
    .err_sgl     (err_sgl),
    .err_dbl     (err_dbl),
    .irq         (irq)
  );

  assign reg_rd_data = status_word(busy, err_sgl, err_dbl);
  assign seq_opcode  = desc_q.opcode;
  assign seq_buf_sel = desc_q.buf_sel;
  assign seq_dev_sel = desc_q.dev_sel;
  assign seq_ecc_en  = desc_q.ecc_en;
  assign seq_multi   = desc_q.multi;
  assign seq_len     = desc_q.len;

  // R5: flags are clear when a command starts
  a_r5_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (!reg_rd_data[R_SGL] && !reg_rd_data[R_DBL]));
  // R8: nonzero write without go bit starts nothing
  a_r8_no_go_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_data[B_GO]) |=> !seq_start);

endmodule

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        seq_start;
  logic [7:0]  seq_opcode;
  logic        seq_buf_sel;
  logic [1:0]  seq_dev_sel;
  logic        seq_ecc_en, seq_multi;
  logic [9:0]  seq_len;
  logic        seq_done = 1'b0, seq_err_single = 1'b0, seq_err_double = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;
  logic [22:0] exp_q[$];

  always #5 clk = ~clk;

  nand_cmd_front uut (.*);

  // Expected start image from a write word, per R2 positions.
  function automatic logic [22:0] expect_of(input logic [31:0] w);
    return {w[23:16], w[14], w[13:12], w[11], w[10], w[9:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: a launch that should be accepted pushes its expected item.
  task automatic wr(input logic [31:0] w, input bit expect_start);
    if (expect_start) exp_q.push_back(expect_of(w));
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = w;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic done(input logic s, input logic d, input bit with_zero_wr);
    @(negedge clk);
    seq_done = 1'b1; seq_err_single = s; seq_err_double = d;
    if (with_zero_wr) begin reg_wr_en = 1'b1; reg_wr_data = '0; end
    @(negedge clk);
    seq_done = 1'b0; seq_err_single = 1'b0; seq_err_double = 1'b0;
    reg_wr_en = 1'b0;
  endtask

  // Monitor: compare each start pulse against the queue head.
  always @(negedge clk) begin
    if (rst_n && seq_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2/R3/R7/R8 unexpected start actual=%h expected=none",
                 {seq_opcode, seq_buf_sel, seq_dev_sel, seq_ecc_en, seq_multi, seq_len});
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        if ({seq_opcode, seq_buf_sel, seq_dev_sel, seq_ecc_en, seq_multi, seq_len} !== e) begin
          failures++;
          $display("FAIL R2 descriptor actual=%h expected=%h",
                   {seq_opcode, seq_buf_sel, seq_dev_sel, seq_ecc_en, seq_multi, seq_len}, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done_run) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, wc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 read", reg_rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 start", {31'b0, seq_start}, 32'h0);

    // R2 launch with irq and ECC
    wa = 32'hC0A5_6A00 | 32'h0000_0200;   // go, irq, op A5, buf1, dev2, ecc1, len 0x200
    wr(wa, 1);
    check("R2 busy", {31'b0, reg_rd_data[31]}, 32'h1);
    // R3 launch while busy
    wb = 32'h8033_0011;
    wr(wb, 0);
    check("R3 opcode kept", {24'b0, seq_opcode}, 32'hA5);
    check("R3 len kept", {22'b0, seq_len}, 32'h200);
    // R8 nonzero write without go
    wr(32'h4000_1234, 0);
    check("R8 busy", {31'b0, reg_rd_data[31]}, 32'h1);
    // R4/R5/R6 done with single-bit error
    done(1'b1, 1'b0, 0);
    check("R4 busy clear", {31'b0, reg_rd_data[31]}, 32'h0);
    check("R5 single", {30'b0, reg_rd_data[11:10]}, 32'h2);
    check("R6 irq set", {31'b0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    check("R6 irq held", {31'b0, irq}, 32'h1);
    wr(32'h0000_0001, 0);
    check("R8 irq unchanged", {31'b0, irq}, 32'h1);
    // R7 zero write
    wr(32'h0, 0);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    check("R7 not busy", {31'b0, reg_rd_data[31]}, 32'h0);

    // Launch without irq, ECC off, boundary fields
    wc = 32'h80FF_77FF;   // op FF, buf1, dev3, ecc0, multi1, len 3FF
    wr(wc, 1);
    check("R5 cleared at launch", {30'b0, reg_rd_data[11:10]}, 32'h0);
    done(1'b0, 1'b1, 0);
    check("R5 ecc off no load", {30'b0, reg_rd_data[11:10]}, 32'h0);
    check("R6 no request no irq", {31'b0, irq}, 32'h0);
    // R4 done while idle
    done(1'b1, 1'b1, 0);
    check("R4 idle done ignored", reg_rd_data, 32'h0);

    // R9 done coincides with zero write
    wr(32'hC012_0804, 1);
    done(1'b0, 1'b1, 1);
    check("R9 irq wins", {31'b0, irq}, 32'h1);
    check("R5 double", {30'b0, reg_rd_data[11:10]}, 32'h1);
    wr(32'h0, 0);
    check("R7 cleared after", {31'b0, irq}, 32'h0);

    repeat (3) @(negedge clk);
    check("R2 all starts seen", exp_q.size(), 32'h0);
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule